// File: doc/BRIEF.md
# Width-Gated Split Register File

This block is the integer register file of a small pipelined core. It holds 32 registers of 32 bits, and each register is stored as two independent 16-bit halves. It has two combinational read ports and one write port that commits on the rising clock edge. Every access carries a one-bit width flag taken from the current instruction. When the flag is set, the access is a full 32-bit operation. When it is clear, the access is a 16-bit operation.

In a 16-bit operation the upper half of each read bus does not switch. The read multiplexer gates the upper-half selection with the width flag. Each read port keeps a small hold register, so that its upper output half repeats the last upper value it drove instead of falling to zero. On the write side, the width flag also enables the upper-half write. A 16-bit write therefore updates only the lower half of the target register.

Register 0 is hardwired to zero, as in common load/store instruction sets. A read that addresses the register being written in the same cycle returns the value stored before the edge.

Top module: `split_regfile`

## Requirements
- R1: After the active-low asynchronous reset, every register holds zero and both held upper read halves are zero. With the width flag set to 1, both read outputs are therefore zero.
- R2: With write enable and width flag both set to 1, a write to a nonzero address stores all 32 data bits at the rising edge. A later 32-bit read of that address returns the full word.
- R3: With write enable set to 1 and width flag set to 0, a write stores data bits [15:0] into the lower half. The upper half [31:16] of that register keeps its previous contents.
- R4: Address 0 always reads as zero on bits [15:0], and on bits [31:16] in 32-bit reads. Writes to address 0 have no effect.
- R5: In a 16-bit read (width flag 0), bits [15:0] of a read output equal the lower half of the addressed register.
- R6: In a 16-bit read, bits [31:16] of a read output equal the upper half that the port presented at the most recent rising edge where the width flag was 1, or zero if there was none since reset. The value does not change when the read address changes.
- R7: A read of the register being written in the same cycle returns the value held before that edge.
- R8: When write enable is 0, no register changes, whatever the write address, data or width flag.
- R9: The two read ports are independent: each returns the contents of its own address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes and upper-half capture happen on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| raddr_a_i | input | 5 | Read address of port A |
| raddr_b_i | input | 5 | Read address of port B |
| waddr_i | input | 5 | Write address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write enable |
| wide_i | input | 1 | Width flag: 1 = 32-bit operation, 0 = 16-bit operation |
| rdata_a_o | output | 32 | Read data of port A |
| rdata_b_o | output | 32 | Read data of port B |

## Verification
A corrupted upper half shows up at the ports only on the first 32-bit read of that register. A 16-bit write that wrongly touched the upper half stays invisible through 16-bit reads, so every batch of writes is followed by a 32-bit sweep of all addresses. A wrong hold register shows at once on the first 16-bit read, as upper bits that are zero or that follow the address. An error in the write decode appears one edge later, when the neighbouring register is read.

// File: rtl/wgrf_pkg.sv
package wgrf_pkg;
  typedef enum logic {
    W_NARROW = 1'b0,
    W_WIDE   = 1'b1
  } width_e;
endpackage

// File: rtl/wgrf_store.sv
module wgrf_store #(
  parameter int ADDR_W = 5,
  parameter int HALF_W = 16,
  parameter int DEPTH  = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic                           wide_i,
  input  logic [ADDR_W-1:0]              waddr_i,
  input  logic [HALF_W-1:0]              wdata_lo_i,
  input  logic [HALF_W-1:0]              wdata_hi_i,
  output logic [DEPTH-1:1][HALF_W-1:0]   lo_o,
  output logic [DEPTH-1:1][HALF_W-1:0]   hi_o
);
  import wgrf_pkg::*;

  logic [DEPTH-1:1][HALF_W-1:0] lo_q, hi_q;

  // entry 0 has no storage
  for (genvar g = 1; g < DEPTH; g++) begin : g_ent
    logic wr_lo, wr_hi;
    assign wr_lo = we_i && (waddr_i == ADDR_W'(g));
    assign wr_hi = wr_lo && (width_e'(wide_i) == W_WIDE);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lo_q[g] <= '0;
      else if (wr_lo) lo_q[g] <= wdata_lo_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hi_q[g] <= '0;
      else if (wr_hi) hi_q[g] <= wdata_hi_i;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  a_r2_wide_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wide_i && waddr_i != '0) |=>
      (lo_q[$past(waddr_i)] == $past(wdata_lo_i) && hi_q[$past(waddr_i)] == $past(wdata_hi_i)));

  a_r3_hi_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wide_i && waddr_i != '0) |=>
      (hi_q == $past(hi_q) && lo_q[$past(waddr_i)] == $past(wdata_lo_i)));

  a_r8_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/wgrf_rd.sv
module wgrf_rd #(
  parameter int ADDR_W = 5,
  parameter int HALF_W = 16,
  parameter int DEPTH  = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wide_i,
  input  logic [ADDR_W-1:0]              raddr_i,
  input  logic [DEPTH-1:1][HALF_W-1:0]   lo_i,
  input  logic [DEPTH-1:1][HALF_W-1:0]   hi_i,
  output logic [HALF_W-1:0]              rd_lo_o,
  output logic [HALF_W-1:0]              rd_hi_o
);
  logic [HALF_W-1:0] sel_lo, sel_hi, hold_q;

  // upper select gated by width, as an extra AND per entry
  always_comb begin
    sel_lo = '0;
    sel_hi = '0;
    for (int i = 1; i < DEPTH; i++) begin
      if (raddr_i == ADDR_W'(i)) begin
        sel_lo = lo_i[i];
        if (wide_i) sel_hi = hi_i[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else if (wide_i) hold_q <= sel_hi;
  end

  assign rd_lo_o = sel_lo;
  assign rd_hi_o = wide_i ? sel_hi : hold_q;

  a_r6_hi_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide_i && $past(!wide_i)) |-> $stable(rd_hi_o));
endmodule

// File: rtl/split_regfile.sv
module split_regfile #(
  parameter int ADDR_W = 5,
  parameter int HALF_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     raddr_a_i,
  input  logic [ADDR_W-1:0]     raddr_b_i,
  input  logic [ADDR_W-1:0]     waddr_i,
  input  logic [2*HALF_W-1:0]   wdata_i,
  input  logic                  we_i,
  input  logic                  wide_i,
  output logic [2*HALF_W-1:0]   rdata_a_o,
  output logic [2*HALF_W-1:0]   rdata_b_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NRD   = 2;

  logic [DEPTH-1:1][HALF_W-1:0] lo_w, hi_w;
  logic [NRD-1:0][ADDR_W-1:0]   raddr;
  logic [NRD-1:0][2*HALF_W-1:0] rdata;

  assign raddr[0] = raddr_a_i;
  assign raddr[1] = raddr_b_i;

  wgrf_store #(.ADDR_W(ADDR_W), .HALF_W(HALF_W), .DEPTH(DEPTH)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .wide_i     (wide_i),
    .waddr_i    (waddr_i),
    .wdata_lo_i (wdata_i[HALF_W-1:0]),
    .wdata_hi_i (wdata_i[2*HALF_W-1:HALF_W]),
    .lo_o       (lo_w),
    .hi_o       (hi_w)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    wgrf_rd #(.ADDR_W(ADDR_W), .HALF_W(HALF_W), .DEPTH(DEPTH)) u_rd (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wide_i  (wide_i),
      .raddr_i (raddr[p]),
      .lo_i    (lo_w),
      .hi_i    (hi_w),
      .rd_lo_o (rdata[p][HALF_W-1:0]),
      .rd_hi_o (rdata[p][2*HALF_W-1:HALF_W])
    );
  end

  assign rdata_a_o = rdata[0];
  assign rdata_b_o = rdata[1];

  a_r4_zero_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_a_i == '0) |-> (rdata_a_o[HALF_W-1:0] == '0));
  a_r4_zero_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_b_i == '0) |-> (rdata_b_o[HALF_W-1:0] == '0));
endmodule

// File: tb/split_regfile_tb.sv
`timescale 1ns/1ps
module split_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  raddr_a = '0, raddr_b = '0, waddr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0, wide = 1'b0;
  logic [31:0] rdata_a, rdata_b;

  int checks = 0;
  int failures = 0;
  logic [31:0] mdl [32];
  logic [15:0] hold_a = '0, hold_b = '0;

  always #4 clk = ~clk;

  split_regfile u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .raddr_a_i(raddr_a), .raddr_b_i(raddr_b),
    .waddr_i(waddr), .wdata_i(wdata),
    .we_i(we), .wide_i(wide),
    .rdata_a_o(rdata_a), .rdata_b_o(rdata_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called just after a rising edge; checks mid-cycle, then commits at next edge
  task automatic step(input string tag, input logic [4:0] wa, input logic [4:0] ra,
                      input logic [4:0] rb, input logic w, input logic wd,
                      input logic [31:0] d);
    logic [31:0] ea, eb;
    waddr = wa; raddr_a = ra; raddr_b = rb; we = w; wide = wd; wdata = d;
    #2;
    ea = {wd ? mdl[ra][31:16] : hold_a, mdl[ra][15:0]};
    eb = {wd ? mdl[rb][31:16] : hold_b, mdl[rb][15:0]};
    chk({tag, " portA"}, rdata_a, ea);
    chk({tag, " portB"}, rdata_b, eb);
    @(posedge clk);
    if (wd) begin
      hold_a = mdl[ra][31:16];
      hold_b = mdl[rb][31:16];
    end
    if (w && wa != 5'd0) begin
      if (wd) mdl[wa] = d;
      else    mdl[wa][15:0] = d[15:0];
    end
    #1;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1: reset state, narrow then wide
    step("R1 narrow", 5'd0, 5'd5, 5'd9, 1'b0, 1'b0, 32'h0);
    step("R1 wide", 5'd0, 5'd17, 5'd31, 1'b0, 1'b1, 32'h0);

    // R7: wide writes with same-cycle read of target; R4 includes address 0
    for (int i = 0; i < 32; i++)
      step("R7 wide", 5'(i), 5'(i), 5'((i + 1) % 32), 1'b1, 1'b1, 32'h9E3779B9 * (i + 1));

    // R2 / R9 / R4: full sweep, ports on different addresses
    for (int i = 0; i < 32; i++)
      step(i == 0 ? "R4 R2" : "R2 R9", 5'd0, 5'(i), 5'(31 - i), 1'b0, 1'b1, 32'h0);

    // R3: narrow writes to odd registers (R7 same-cycle read), then wide sweep
    for (int i = 1; i < 32; i += 2)
      step("R7 narrow", 5'(i), 5'(i), 5'(i - 1), 1'b1, 1'b0, 32'hC0DE0000 ^ (i * 32'h00013579));
    step("R4 narrow wr0", 5'd0, 5'd0, 5'd0, 1'b1, 1'b0, 32'hFFFFFFFF);
    for (int i = 0; i < 32; i++)
      step("R3", 5'd0, 5'(i), 5'((i + 7) % 32), 1'b0, 1'b1, 32'h0);

    // R8: disabled writes of both widths, then check all contents
    for (int i = 0; i < 32; i++)
      step("R8 idle", 5'(i), 5'(31 - i), 5'(i), 1'b0, 5'(i) % 2 == 0, 32'hFFFF_FFFF ^ i);
    for (int i = 0; i < 32; i++)
      step("R8", 5'd0, 5'(i), 5'(31 - i), 1'b0, 1'b1, 32'h0);

    // R5 / R6: capture a distinct upper half per port, then narrow sweep
    step("R6 capture", 5'd0, 5'd7, 5'd20, 1'b0, 1'b1, 32'h0);
    for (int i = 0; i < 32; i++)
      step("R5 R6", 5'd0, 5'(i), 5'(31 - i), 1'b0, 1'b0, 32'h0);
    step("R6 recapture", 5'd0, 5'd3, 5'd0, 1'b0, 1'b1, 32'h0);
    for (int i = 0; i < 32; i++)
      step("R5 R6 again", 5'd0, 5'((i * 5) % 32), 5'((i * 11) % 32), 1'b0, 1'b0, 32'h0);

    // R6 during narrow writes: held half unaffected by write of addressed reg
    for (int i = 2; i < 32; i += 4)
      step("R6 R3 narrow wr", 5'(i), 5'(i), 5'(i), 1'b1, 1'b0, 32'h1234ABCD + i);
    for (int i = 0; i < 32; i++)
      step("R3 final", 5'd0, 5'(i), 5'(i ^ 5'h1F), 1'b0, 1'b1, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule